// File: doc/BRIEF.md
# Power-Up Strap Capture and Frequency-Code Selector

This block sits beside the reference-clock domain of a motherboard clock generator. Four package pins are shared between two jobs. For a short window after power-up they are read as configuration straps: one pin picks desktop or mobile operation, and three pins give a hardware frequency code. Once that window closes, the block captures their levels, and one reference cycle later it turns on the output drivers of those pins so that they can carry their clock outputs.

After capture, a control byte held in the block decides where the active 3-bit frequency code comes from. It is either the captured strap code or a code written into the byte. The same byte also produces the spread-spectrum controls, and those are held off while the hardware code is in use. The block reports the mode flag, the output enables for the shared pins and for the mode-dependent pin pair, the frequency code and the spread-spectrum controls. Producing the clocks themselves is done elsewhere.

Top module: `strap_select_top`

## Requirements
- R1: While `rst_n` is low, every output is 0. That covers `strap_oe`, `pair_oe`, `freq_code`, `desktop_mode`, `ss_enable`, `ss_down` and `ss_narrow`.
- R2: `rst_n` is released through a two-stage synchroniser. `strap_oe` stays all zero through the (WINDOW_CYCLES+2)-th rising clock edge after the release. It becomes all ones at the (WINDOW_CYCLES+3)-th edge.
- R3: At the (WINDOW_CYCLES+2)-th rising edge after release, `pad_in` is captured. `pad_in[3]` becomes `desktop_mode` (1 means desktop, 0 means mobile). `pad_in[2:0]` become the hardware code, with bit 0 taken from FS0, bit 1 from FS1 and bit 2 from FS2.
- R4: After capture, changes on `pad_in` have no effect on `desktop_mode` or on the hardware code until the next reset.
- R5: The control byte resets to 8'h70. With control bit 3 at 0, `freq_code` equals the captured hardware code.
- R6: A write (`cfg_we` high at a rising edge) with data bit 3 set makes `freq_code` equal to data bits 6:4 from that same edge on. The byte's own code overrides the strap code.
- R7: While control bit 3 is 0, `ss_enable`, `ss_down` and `ss_narrow` are 0, whatever bits 1, 2 and 7 hold.
- R8: While control bit 3 is 1, `ss_enable` follows bit 1 and `ss_down` follows bit 2 (1 means down spread, 0 means center spread). `ss_narrow` follows bit 7 (1 means ±0.5%, 0 means ±1.5%).
- R9: `pair_oe` is 1 exactly when `desktop_mode` is 1 and the strap drivers are on. In mobile mode the pin pair stays an input pair.
- R10: A write that clears bit 3 returns `freq_code` to the captured hardware code on the edge of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| pad_in | input | 4 | Levels on the shared pins: {mode, FS2, FS1, FS0} |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| strap_oe | output | 4 | Output-driver enables for the shared pins |
| pair_oe | output | 1 | Output enable for the pin pair used as memory clocks in desktop mode |
| desktop_mode | output | 1 | Captured mode: 1 desktop, 0 mobile |
| freq_code | output | 3 | Active frequency code (3'b111 gives 100.2/33.4 MHz, 3'b011 gives 66.5/33.2 MHz) |
| ss_enable | output | 1 | Spread-spectrum enable |
| ss_down | output | 1 | Down spread when 1, center spread when 0 |
| ss_narrow | output | 1 | ±0.5% when 1, ±1.5% when 0 |

## Verification
All sixteen strap patterns are applied, one per reset. The pins hold the complement of each pattern until one cycle before the capture edge and the complement again right after it. This separates capture at the correct edge from capture one edge too early or too late, and it shows whether the capture is frozen afterwards. Under every pattern, all 256 control-byte values are written in turn. The code source, the spread-spectrum gating and the three spread controls are checked against arithmetic on the written byte and the strap value. Because bit 3 toggles every eight writes, this also exercises each switch between strap code and byte code.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int FS_W = 3;
  localparam int PAD_W = FS_W + 1;
  localparam logic [7:0] CFG_RESET = 8'h70;
  localparam int B_SS_EN = 1;
  localparam int B_SS_DOWN = 2;
  localparam int B_SRC = 3;
  localparam int B_CODE_LO = 4;
  localparam int B_SS_NARROW = 7;
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/strap_window.sv
module strap_window #(
  parameter int WINDOW_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic sample_o,
  output logic drive_o
);
  localparam int CW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;
  logic drive_q, drive_d;
  logic sample;

  always_comb begin
    sample  = !done_q && (cnt_q == LAST);
    cnt_d   = cnt_q;
    if (!done_q && !sample) cnt_d = cnt_q + 1'b1;
    done_d  = done_q | sample;
    drive_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      drive_q <= drive_d;
    end
  end

  assign sample_o = sample;
  assign drive_o  = drive_q;
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;

  always_comb q_d = en ? d : q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/strap_cfg_reg.sv
module strap_cfg_reg #(
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] q
);
  logic [7:0] q_r, q_d;

  always_comb q_d = we ? wdata : q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RESET_VAL;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/strap_select_top.sv
module strap_select_top
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAD_W-1:0] pad_in,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [PAD_W-1:0] strap_oe,
  output logic             pair_oe,
  output logic             desktop_mode,
  output logic [FS_W-1:0]  freq_code,
  output logic             ss_enable,
  output logic             ss_down,
  output logic             ss_narrow
);
  logic             rst_sync_n;
  logic             sample;
  logic             drive;
  logic [PAD_W-1:0] lat_q;
  logic [7:0]       cfg_q;
  logic             use_reg;
  logic             rst_view;

  strap_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  strap_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_win (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sample_o (sample),
    .drive_o  (drive)
  );

  strap_capture #(.W(PAD_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (sample),
    .d     (pad_in),
    .q     (lat_q)
  );

  strap_cfg_reg #(.RESET_VAL(CFG_RESET)) u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  // Every shared pin switches from strap input to clock output together.
  for (genvar gi = 0; gi < PAD_W; gi++) begin : g_oe
    assign strap_oe[gi] = drive;
  end

  // Reset masks the register reset value while rst_n is low.
  assign rst_view = rst_n & rst_sync_n;

  always_comb begin
    use_reg      = cfg_q[B_SRC] & rst_view;
    desktop_mode = lat_q[PAD_W-1];
    pair_oe      = lat_q[PAD_W-1] & drive;
    freq_code    = use_reg ? cfg_q[B_CODE_LO +: FS_W] : lat_q[FS_W-1:0];
    ss_enable    = use_reg & cfg_q[B_SS_EN];
    ss_down      = use_reg & cfg_q[B_SS_DOWN];
    ss_narrow    = use_reg & cfg_q[B_SS_NARROW];
  end
endmodule

// File: rtl/strap_select_chk.sv
module strap_select_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [3:0] strap_oe,
  input logic       pair_oe,
  input logic       desktop_mode,
  input logic [3:0] lat_q,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [2:0] freq_code,
  input logic       ss_enable,
  input logic       ss_down,
  input logic       ss_narrow
);
  AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strap_oe == 4'h0) || (strap_oe == 4'hF)); // R2

  AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    strap_oe[0] |=> strap_oe[0]); // R2

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    strap_oe[0] |=> $stable(lat_q)); // R4

  AST_REG_CODE_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_wdata[3]) |=> (freq_code == $past(cfg_wdata[6:4]))); // R6

  AST_SS_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && !cfg_wdata[3]) |=> (!ss_enable && !ss_down && !ss_narrow)); // R7

  AST_SS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_wdata[3]) |=> (ss_enable == $past(cfg_wdata[1]) &&
                                  ss_down == $past(cfg_wdata[2]) &&
                                  ss_narrow == $past(cfg_wdata[7]))); // R8

  AST_PAIR_DESKTOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pair_oe |-> (desktop_mode && strap_oe[3])); // R9

  AST_HW_RETURN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && !cfg_wdata[3]) |=> (freq_code == lat_q[2:0])); // R10
endmodule

bind strap_select_top strap_select_chk u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .strap_oe     (strap_oe),
  .pair_oe      (pair_oe),
  .desktop_mode (desktop_mode),
  .lat_q        (lat_q),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .freq_code    (freq_code),
  .ss_enable    (ss_enable),
  .ss_down      (ss_down),
  .ss_narrow    (ss_narrow)
);

// File: tb/test_strap_select_top.sv
`timescale 1ns/1ps
module test_strap_select_top;
  localparam int WIN = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pad_in = 4'h0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [3:0] strap_oe;
  logic       pair_oe;
  logic       desktop_mode;
  logic [2:0] freq_code;
  logic       ss_enable, ss_down, ss_narrow;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  strap_select_top #(.WINDOW_CYCLES(WIN)) i_strap_select_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .pad_in       (pad_in),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .strap_oe     (strap_oe),
    .pair_oe      (pair_oe),
    .desktop_mode (desktop_mode),
    .freq_code    (freq_code),
    .ss_enable    (ss_enable),
    .ss_down      (ss_down),
    .ss_narrow    (ss_narrow)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    for (int p = 0; p < 16; p++) begin
      logic [3:0] pat;
      pat = 4'(p);
      rst_n = 1'b0;
      cfg_we = 1'b0;
      pad_in = ~pat;
      repeat (2) @(negedge clk);
      // R1: all outputs low in reset
      check("R1", {strap_oe, pair_oe, desktop_mode, ss_enable, ss_down}, 8'h00);
      check("R1", {5'd0, freq_code}, 8'h00);
      check("R1", {7'd0, ss_narrow}, 8'h00);
      rst_n = 1'b1;
      for (int k = 0; k < WIN + 1; k++) @(negedge clk);
      pad_in = pat;
      @(negedge clk);
      check("R2", {4'd0, strap_oe}, 8'h00);
      check("R3", {4'd0, desktop_mode, freq_code}, {4'd0, pat});
      pad_in = ~pat;
      @(negedge clk);
      check("R2", {4'd0, strap_oe}, 8'h0F);
      check("R9", {7'd0, pair_oe}, {7'd0, pat[3]});
      repeat (3) @(negedge clk);
      check("R4", {4'd0, desktop_mode, freq_code}, {4'd0, pat});
      check("R5", {5'd0, freq_code}, {5'd0, pat[2:0]});
      check("R7", {5'd0, ss_enable, ss_down, ss_narrow}, 8'h00);
      for (int w = 0; w < 256; w++) begin
        logic [7:0] wb;
        logic [2:0] exp_code;
        logic [2:0] exp_ss;
        wb = 8'(w);
        pad_in = 4'(w);
        cfg_we = 1'b1;
        cfg_wdata = wb;
        @(negedge clk);
        cfg_we = 1'b0;
        exp_code = wb[3] ? wb[6:4] : pat[2:0];
        exp_ss = wb[3] ? {wb[1], wb[2], wb[7]} : 3'b000;
        if (wb[3]) begin
          check("R6", {5'd0, freq_code}, {5'd0, exp_code});
          check("R8", {5'd0, ss_enable, ss_down, ss_narrow}, {5'd0, exp_ss});
        end else begin
          check("R10", {5'd0, freq_code}, {5'd0, exp_code});
          check("R7", {5'd0, ss_enable, ss_down, ss_narrow}, {5'd0, exp_ss});
        end
        check("R4", {6'd0, desktop_mode, pair_oe}, {6'd0, pat[3], pat[3]});
      end
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule